// File: doc/BRIEF.md
# Dual-Core C-State Coordinator

This block tracks the power state of two processor cores and works out which package-wide low-power state the pair can safely share. Each core sits in one of five states: running (C0), halted (C1), or one of three deeper sleep levels (C2, C3, C4/C6). Single-cycle event inputs stand in for the things that move a core: a halt instruction, a deep-sleep request, five kinds of wake event, and the exit from a system-management handler.

The package state is chosen by the shallowest core. If either core is running or halted, the package stays Normal. Otherwise the shallowest sleeping core selects Stop-Grant (C2), Deep Sleep (C3), or Deeper Sleep, and Deeper Sleep needs both cores in C4/C6. A core woken out of a halt by a system-management interrupt stores where it should resume. When the handler exits, the core goes back to halt or to running as that stored choice says. The resolved package code is registered for a downstream sequencer that drives clocks and voltages.

Top module: `cstate_coord`

## Requirements
- R1: While reset is asserted and right after it, every core reads C0 and the package code is Normal. Core state codes are C0=0, C1=1, C2=2, C3=3, C4/C6=4. Package codes are Normal=0, Stop-Grant=1, Deep Sleep=2, Deeper Sleep=3.
- R2: A halt pulse on a core in C0 puts that core in C1 at the next clock edge.
- R3: A core in C1 returns to C0 at the next edge on any one of its wake inputs: SMI, INIT, NMI, INTR or bus interrupt message.
- R4: Any wake input also returns a core in C2, C3 or C4/C6 to C0 at the next edge.
- R5: A wake input beats a halt or sleep request to the same core in the same cycle, so the core ends in C0.
- R6: A halt and a sleep request to a C0 core in the same cycle put the core in C1.
- R7: The package code is Normal whenever at least one core is in C0 or C1.
- R8: When no core is in C0 or C1, the package code is Stop-Grant if the shallowest core is in C2 and Deep Sleep if it is in C3. It is Deeper Sleep only when all cores are in C4/C6.
- R9: An SMI stores a resume target for the core. The target is halt only when the core was in C1 and its return-select input was high at that moment; otherwise it is running. The next handler-exit pulse then moves the core to C1 (halt target) or C0 (running target). A wake input in the same cycle as the exit takes priority.
- R10: A handler-exit pulse with no SMI outstanding has no effect on the core state.
- R11: Halt and sleep requests are accepted only in C0. A core in C1 or deeper ignores them. The sleep level code is 1=C2, 2=C3, 3=C4/C6, and code 0 has no effect.
- R12: The package code is registered. It reflects the core states held during the previous cycle.
- R13: Pulling the reset input low forces C0 and Normal at once, without waiting for a clock. After reset is released, the first two clock edges still leave the block in reset, and inputs are acted on from the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 2 | Halt pulse, one bit per core |
| sleep_req_i | input | 2 | Deep-sleep request pulse, one bit per core |
| sleep_lvl_i | input | 4 | Requested sleep level, two bits per core (1=C2, 2=C3, 3=C4/C6) |
| smi_i | input | 2 | System-management interrupt wake, per core |
| init_i | input | 2 | INIT wake, per core |
| nmi_i | input | 2 | Non-maskable interrupt wake, per core |
| intr_i | input | 2 | Maskable interrupt wake, per core |
| msgint_i | input | 2 | Bus interrupt-message wake, per core |
| smi_exit_i | input | 2 | Handler-exit pulse, per core |
| smi_ret_halt_i | input | 2 | Resume-in-halt select, sampled when an SMI arrives |
| core_state_o | output | 6 | Per-core state code, three bits per core, core 0 in the low bits |
| pkg_state_o | output | 2 | Registered package state code |

## Verification
The bench targets three groups of cases. The first is priority collisions: a wake arriving with a halt, and a halt arriving with a sleep request. A design that ordered these wrongly would leave a core asleep after an interrupt. The second is the mixed-state package mapping, such as C4 paired with C3 or C4 paired with C1. A design that took the deeper core, or granted Deeper Sleep too early, would report a deeper package state than the shallower core allows. The third is the resume-target bookkeeping: SMI from halt with each select value, SMI from a deep state, and an exit with no SMI outstanding. A design that sampled the target at exit time, or acted on stray exits, would resume the wrong core state. The one-cycle lag of the package code and the two-edge reset release are checked cycle by cycle, because an unregistered or one-stage version would show up one cycle early.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

  localparam int unsigned CST_W  = 3;
  localparam int unsigned PKG_W  = 2;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned WAKE_N = 5;

  // Core power states: the numeric order is the depth order
  typedef enum logic [CST_W-1:0] {
    CS_C0  = 3'd0,
    CS_C1  = 3'd1,
    CS_C2  = 3'd2,
    CS_C3  = 3'd3,
    CS_C46 = 3'd4
  } core_cst_e;

  // Package power states handed to the sequencer
  typedef enum logic [PKG_W-1:0] {
    PK_NORMAL  = 2'd0,
    PK_STOPGNT = 2'd1,
    PK_DEEP    = 2'd2,
    PK_DEEPER  = 2'd3
  } pkg_cst_e;

  // Bit position of SMI inside the per-core wake vector
  localparam int unsigned WAKE_SMI = 0;

endpackage

// File: rtl/cstate_rst_sync.sv
module cstate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cstate_core_fsm.sv
module cstate_core_fsm
  import cstate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              sleep_req_i,
  input  logic [LVL_W-1:0]  sleep_lvl_i,
  input  logic [WAKE_N-1:0] wake_i,
  input  logic              smi_exit_i,
  input  logic              ret_halt_i,
  output core_cst_e         state_o
);

  core_cst_e state_q, state_d;
  logic      in_smm_q, in_smm_d;
  logic      tgt_halt_q, tgt_halt_d;
  logic      tgt_en;
  logic      any_wake;
  logic      exit_hit;
  core_cst_e sleep_tgt;
  logic      sleep_ok;

  assign any_wake = |wake_i;
  assign exit_hit = smi_exit_i & in_smm_q;
  assign tgt_en   = wake_i[WAKE_SMI];

  // Requested sleep level decode
  always_comb begin
    sleep_ok  = 1'b1;
    sleep_tgt = CS_C2;
    case (sleep_lvl_i)
      2'd1:    sleep_tgt = CS_C2;
      2'd2:    sleep_tgt = CS_C3;
      2'd3:    sleep_tgt = CS_C46;
      default: sleep_ok  = 1'b0;
    endcase
  end

  // Next state: wake > handler exit > halt > sleep request
  always_comb begin
    state_d    = state_q;
    in_smm_d   = in_smm_q;
    tgt_halt_d = tgt_halt_q;
    if (any_wake) begin
      state_d = CS_C0;
      if (wake_i[WAKE_SMI]) begin
        in_smm_d   = 1'b1;
        tgt_halt_d = ret_halt_i & (state_q == CS_C1);
      end
    end else if (exit_hit) begin
      state_d  = tgt_halt_q ? CS_C1 : CS_C0;
      in_smm_d = 1'b0;
    end else if (state_q == CS_C0) begin
      if (halt_i)                     state_d = CS_C1;
      else if (sleep_req_i && sleep_ok) state_d = sleep_tgt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CS_C0;
      in_smm_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      in_smm_q <= in_smm_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgt_halt_q <= 1'b0;
    else if (tgt_en) tgt_halt_q <= tgt_halt_d;
  end

  assign state_o = state_q;

  // R4 and R3: any wake brings a sleeping or halted core back to C0
  a_r4_wake_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != CS_C0 && any_wake) |=> state_q == CS_C0);

  // R2: halt from C0 with nothing of higher priority enters C1
  a_r2_halt_enters_c1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CS_C0 && halt_i && !any_wake && !exit_hit) |=> state_q == CS_C1);

  // R11: a non-running core ignores halt and sleep requests
  a_r11_busy_core_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != CS_C0 && !any_wake && !exit_hit) |=> $stable(state_q));

  // R10: an exit with no outstanding SMI changes nothing
  a_r10_stray_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_smm_q && smi_exit_i && !any_wake && !halt_i && !sleep_req_i)
      |=> $stable(state_q));

endmodule

// File: rtl/cstate_pkg_resolve.sv
module cstate_pkg_resolve
  import cstate_pkg::*;
#(
  parameter int unsigned NCORES = 2
) (
  input  logic [NCORES*CST_W-1:0] states_i,
  output logic [PKG_W-1:0]        pkg_o
);

  logic [CST_W-1:0] shallow;

  // Shallowest core state across all cores
  always_comb begin
    shallow = CS_C46;
    for (int i = 0; i < NCORES; i++) begin
      if (states_i[i*CST_W +: CST_W] < shallow) shallow = states_i[i*CST_W +: CST_W];
    end
  end

  always_comb begin
    case (shallow)
      CS_C0, CS_C1: pkg_o = PK_NORMAL;
      CS_C2:        pkg_o = PK_STOPGNT;
      CS_C3:        pkg_o = PK_DEEP;
      default:      pkg_o = PK_DEEPER;
    endcase
  end

endmodule

// File: rtl/cstate_coord.sv
module cstate_coord
  import cstate_pkg::*;
#(
  parameter int unsigned NCORES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NCORES-1:0]       halt_i,
  input  logic [NCORES-1:0]       sleep_req_i,
  input  logic [NCORES*2-1:0]     sleep_lvl_i,
  input  logic [NCORES-1:0]       smi_i,
  input  logic [NCORES-1:0]       init_i,
  input  logic [NCORES-1:0]       nmi_i,
  input  logic [NCORES-1:0]       intr_i,
  input  logic [NCORES-1:0]       msgint_i,
  input  logic [NCORES-1:0]       smi_exit_i,
  input  logic [NCORES-1:0]       smi_ret_halt_i,
  output logic [NCORES*3-1:0]     core_state_o,
  output logic [1:0]              pkg_state_o
);

  localparam int unsigned ST_BUS_W = NCORES * CST_W;

  logic                rst_sync_n;
  logic [ST_BUS_W-1:0] st_bus;
  logic [PKG_W-1:0]    pkg_d, pkg_q;
  logic                pkg_en;

  cstate_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_core
    core_cst_e   st;
    logic [WAKE_N-1:0] wk;

    assign wk = {msgint_i[g], intr_i[g], nmi_i[g], init_i[g], smi_i[g]};

    cstate_core_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .halt_i      (halt_i[g]),
      .sleep_req_i (sleep_req_i[g]),
      .sleep_lvl_i (sleep_lvl_i[g*LVL_W +: LVL_W]),
      .wake_i      (wk),
      .smi_exit_i  (smi_exit_i[g]),
      .ret_halt_i  (smi_ret_halt_i[g]),
      .state_o     (st)
    );

    assign st_bus[g*CST_W +: CST_W] = st;
  end

  cstate_pkg_resolve #(.NCORES(NCORES)) u_resolve (
    .states_i (st_bus),
    .pkg_o    (pkg_d)
  );

  assign pkg_en = (pkg_d != pkg_q);

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  pkg_q <= PK_NORMAL;
    else if (pkg_en)  pkg_q <= pkg_d;
  end

  assign core_state_o = st_bus;
  assign pkg_state_o  = pkg_q;

  // Observation flags for the package-level assertions
  logic any_active, all_deepest;
  always_comb begin
    any_active  = 1'b0;
    all_deepest = 1'b1;
    for (int i = 0; i < NCORES; i++) begin
      if (st_bus[i*CST_W +: CST_W] <= CS_C1)  any_active  = 1'b1;
      if (st_bus[i*CST_W +: CST_W] != CS_C46) all_deepest = 1'b0;
    end
  end

  // R7: one active core keeps the package Normal
  a_r7_normal_when_active: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    any_active |=> pkg_state_o == PK_NORMAL);

  // R8: every core in C4/C6 gives Deeper Sleep
  a_r8_deeper_all_deep: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    all_deepest |=> pkg_state_o == PK_DEEPER);

  // R8: Deeper Sleep never shows while some core was shallower
  a_r8_no_early_deeper: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !all_deepest |=> pkg_state_o != PK_DEEPER);

endmodule

// File: tb/cstate_coord_test.sv
`timescale 1ns/1ps
module cstate_coord_test;

  localparam int N = 2;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]   halt, sreq, smi, init, nmi, intr, msgi, sexit, rethalt;
  logic [2*N-1:0] lvl;
  logic [3*N-1:0] cst;
  logic [1:0]     pst;

  always #(HALF) clk = ~clk;

  cstate_coord #(.NCORES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .sleep_req_i(sreq),
    .sleep_lvl_i(lvl), .smi_i(smi), .init_i(init), .nmi_i(nmi), .intr_i(intr),
    .msgint_i(msgi), .smi_exit_i(sexit), .smi_ret_halt_i(rethalt),
    .core_state_o(cst), .pkg_state_o(pst)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model
  int m_st[N];
  bit m_smm[N];
  bit m_tgt[N];
  int m_pkg;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f_pkg();
    int sh = 4;
    for (int i = 0; i < N; i++) if (m_st[i] < sh) sh = m_st[i];
    if (sh <= 1) return 0;
    if (sh == 2) return 1;
    if (sh == 3) return 2;
    return 3;
  endfunction

  function automatic int f_core(int c);
    return int'(cst[c*3 +: 3]);
  endfunction

  task automatic idle_in();
    halt = '0; sreq = '0; lvl = '0; smi = '0; init = '0; nmi = '0;
    intr = '0; msgi = '0; sexit = '0; rethalt = '0;
  endtask

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin m_st[c] = 0; m_smm[c] = 0; m_tgt[c] = 0; end
    m_pkg = 0;
  endtask

  // Called at a falling edge with the stimulus set: advance one cycle and compare
  task automatic step(string tag);
    m_pkg = f_pkg();
    for (int c = 0; c < N; c++) begin
      bit wk = smi[c] | init[c] | nmi[c] | intr[c] | msgi[c];
      int lv = int'(lvl[c*2 +: 2]);
      if (wk) begin
        if (smi[c]) begin m_smm[c] = 1; m_tgt[c] = rethalt[c] && (m_st[c] == 1); end
        m_st[c] = 0;
      end else if (sexit[c] && m_smm[c]) begin
        m_st[c] = m_tgt[c] ? 1 : 0; m_smm[c] = 0;
      end else if (m_st[c] == 0 && halt[c]) begin
        m_st[c] = 1;
      end else if (m_st[c] == 0 && sreq[c] && lv != 0) begin
        m_st[c] = 1 + lv;
      end
    end
    @(negedge clk);
    idle_in();
    for (int c = 0; c < N; c++) chk(tag, f_core(c), m_st[c]);
    chk(tag, int'(pst), m_pkg);
  endtask

  task automatic wake_all();
    intr = '1; step("R4");
  endtask

  initial begin
    #(2*HALF*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in();
    model_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 core0 in reset", f_core(0), 0);
    chk("R1 core1 in reset", f_core(1), 0);
    chk("R1 pkg in reset", int'(pst), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 core0 after reset", f_core(0), 0);
    chk("R1 pkg after reset", int'(pst), 0);

    // R2 halt, R7 package stays Normal
    halt = 2'b01; step("R2");
    chk("R2 core0 halted", f_core(0), 1);
    step("R7");
    chk("R7 halted+running pkg", int'(pst), 0);

    // R3 each wake type from C1
    for (int k = 0; k < 5; k++) begin
      halt = 2'b10; step("R2");
      case (k)
        0: smi[1] = 1'b1;
        1: init[1] = 1'b1;
        2: nmi[1] = 1'b1;
        3: intr[1] = 1'b1;
        default: msgi[1] = 1'b1;
      endcase
      step("R3");
      chk("R3 wake from C1", f_core(1), 0);
      if (k == 0) begin sexit[1] = 1'b1; step("R9"); chk("R9 exit to C0", f_core(1), 0); end
    end

    // R5 wake beats halt and sleep requests
    halt = 2'b01; nmi = 2'b01; sreq = 2'b10; lvl = 4'b1100; intr = 2'b10;
    step("R5");
    chk("R5 halt+wake core0", f_core(0), 0);
    chk("R5 sleep+wake core1", f_core(1), 0);

    // R6 halt beats sleep request
    halt = 2'b01; sreq = 2'b01; lvl = 4'b0011; step("R6");
    chk("R6 halt over sleep", f_core(0), 1);
    wake_all();

    // R7/R8 package mapping: entries {lvl0, lvl1, pkg}; lvl 0 means halt, 9 means stay C0
    begin
      int tab[8][3] = '{'{1,1,1}, '{2,1,1}, '{2,2,2}, '{3,2,2},
                        '{3,3,3}, '{3,0,0}, '{3,9,0}, '{1,3,1}};
      for (int e = 0; e < 8; e++) begin
        for (int c = 0; c < N; c++) begin
          if (tab[e][c] == 0) halt[c] = 1'b1;
          else if (tab[e][c] != 9) begin sreq[c] = 1'b1; lvl[c*2 +: 2] = 2'(tab[e][c]); end
        end
        step("R8");
        step("R8");
        chk(tab[e][2] == 0 ? "R7 mixed pkg" : "R8 mixed pkg", int'(pst), tab[e][2]);
        wake_all();
      end
    end

    // R12 registered package lag
    sreq = 2'b11; lvl = 4'b1010; step("R12");
    chk("R12 core0 now C3", f_core(0), 3);
    chk("R12 pkg still Normal", int'(pst), 0);
    step("R12");
    chk("R12 pkg now Deep", int'(pst), 2);
    init = 2'b11; step("R4");
    chk("R4 core0 from C3", f_core(0), 0);
    chk("R4 core1 from C3", f_core(1), 0);

    // R9 resume target
    halt = 2'b01; step("R2");
    smi = 2'b01; rethalt = 2'b01; step("R9");
    chk("R9 smi wakes", f_core(0), 0);
    sexit = 2'b01; step("R9");
    chk("R9 resume halt", f_core(0), 1);
    smi = 2'b01; rethalt = 2'b00; step("R9");
    sexit = 2'b01; step("R9");
    chk("R9 resume run", f_core(0), 0);
    sreq = 2'b01; lvl = 4'b0010; step("R9");
    smi = 2'b01; rethalt = 2'b01; step("R9");
    sexit = 2'b01; step("R9");
    chk("R9 smi from C3 resumes run", f_core(0), 0);

    // R10 stray exit, R11 requests ignored off C0
    sreq = 2'b10; lvl = 4'b0100; halt = 2'b01; step("R11");
    sexit = 2'b10; step("R10");
    chk("R10 stray exit ignored", f_core(1), 2);
    halt = 2'b10; step("R11");
    chk("R11 halt ignored in C2", f_core(1), 2);
    sreq = 2'b11; lvl = 4'b1110; step("R11");
    chk("R11 sleep ignored in C2", f_core(1), 2);
    chk("R11 sleep ignored in C1", f_core(0), 1);
    sreq = 2'b00; step("R11");
    wake_all();

    // Random phase
    for (int t = 0; t < 4000; t++) begin
      for (int c = 0; c < N; c++) begin
        halt[c]    = ($urandom % 100) < 15;
        sreq[c]    = ($urandom % 100) < 25;
        lvl[c*2 +: 2] = 2'($urandom % 4);
        smi[c]     = ($urandom % 100) < 3;
        init[c]    = ($urandom % 100) < 2;
        nmi[c]     = ($urandom % 100) < 2;
        intr[c]    = ($urandom % 100) < 3;
        msgi[c]    = ($urandom % 100) < 2;
        sexit[c]   = ($urandom % 100) < 6;
        rethalt[c] = ($urandom % 100) < 50;
      end
      step("R12");
    end

    // R13 async reset mid-sleep and two-edge release
    sreq = 2'b11; lvl = 4'b1111; step("R13");
    step("R13");
    rst_n = 1'b0;
    #1;
    chk("R13 core0 async clear", f_core(0), 0);
    chk("R13 core1 async clear", f_core(1), 0);
    chk("R13 pkg async clear", int'(pst), 0);
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    halt = 2'b01;
    @(negedge clk);
    chk("R13 edge1 still reset", f_core(0), 0);
    @(negedge clk);
    chk("R13 edge2 still reset", f_core(0), 0);
    @(negedge clk);
    idle_in();
    chk("R13 edge3 acts", f_core(0), 1);
    m_st[0] = 1;
    step("R13");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule